// File: doc/BRIEF.md
# Shared Cycle Counter with Per-Context Compare Timers

This block holds one free-running cycle counter shared by several processor contexts. The counter is up to 64 bits wide and is reached over a 32-bit register port as a low word and a high word. Software reads the high word, then the low word, then the high word again, and retries when the two high values differ. That protocol only works if the high word changes solely through a carry out of the low word, and the counter guarantees this. Software can halt and resume the counter through a stop bit, can load either half, and can read the implemented width from a configuration field.

Each context owns a 64-bit compare register and a timer interrupt line. A context writes its own compare through a local window, which is selected by the requester index `bus_ctx`. It can also reach any other context's compare: it first stores a target index in its own selector register and then uses the remote window. A compare high-half write only stages the value. The following low-half write commits both halves at once, so no match can come from a half-updated compare. A match makes the interrupt pending, and it stays pending until that compare register is written again.

The counter control is a two-state machine. CNT_RUN moves to CNT_HALT on a configuration write with the stop bit set. CNT_HALT moves back to CNT_RUN on a configuration write with the stop bit clear. Each context has a two-state machine as well. CMP_ARMED moves to CMP_PENDING when the counter equals the committed compare and no compare write happens in that cycle. CMP_PENDING moves back to CMP_ARMED on any write to either half of that context's compare.

Top module: `shared_timer`

## Requirements
- R1: After reset the counter is zero and running, every timer interrupt is low, and every compare register holds all ones within the counter width.
- R2: While running, the counter advances by exactly one per clock. The low word is read at address 1 and the high word at address 2.
- R3: The high word changes only when the low word carries out of all ones, or when the high word is written.
- R4: Address 0 bit 0 is the stop bit. Writing 1 halts the counter and writing 0 resumes it. Reading bit 0 returns 1 while halted. A counter that is halted by a write at one clock edge still advances at that edge, and a counter resumed at an edge first advances at the following edge.
- R5: Address 0 bits 11:8 report K, giving a counter width of 32+4K bits. Counter and compare bits above that width read as zero, and the counter wraps to zero at that width.
- R6: A write to address 1 or address 2 replaces that half of the counter and takes precedence over the increment in the same cycle.
- R7: A context's interrupt rises one clock after the counter equals its committed compare. It stays high until either half of that compare is written, and it is low in the clock after such a write.
- R8: A compare high-half write is staged and leaves the committed compare unchanged. A compare low-half write commits the low data together with the staged high half.
- R9: The local window, with the low half at address 8 and the high half at address 9, reads and writes only the compare of the context given by `bus_ctx`.
- R10: Address 4 is the requester's 8-bit target selector. The remote window, with the low half at address 12 and the high half at address 13, reaches the selected context's compare. When the selector is not below the context count, remote writes are ignored and remote reads return zero.
- R11: Read data appears on `bus_rdata` one clock after the read request. Unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_ctx | input | CTX_W | Index of the requesting context |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| timer_irq | output | NCTX | Per-context compare interrupt |

## Verification
A read presents its data at the first clock edge after the request, so the bench samples `bus_rdata` at the falling edge that follows. A counter write shows up in the same way. A resume written at edge E produces the first increment at E+1. A compare set to counter-plus-d therefore matches after edge E+d, and the interrupt rises at E+d+1. The bench checks that the interrupt is still low at E+d and high at E+d+1. A compare write clears the interrupt by the falling edge right after it. Every check samples at a falling edge, at the cycle counted this way.

// File: rtl/shtmr_pkg.sv
package shtmr_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CFG     = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd2;
    localparam logic [ADDR_W-1:0] A_OSEL    = 4'd4;
    localparam logic [ADDR_W-1:0] A_CMP_LO  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CMP_HI  = 4'd9;
    localparam logic [ADDR_W-1:0] A_OCMP_LO = 4'd12;
    localparam logic [ADDR_W-1:0] A_OCMP_HI = 4'd13;

    typedef enum logic {CNT_RUN, CNT_HALT} cnt_state_e;
    typedef enum logic {CMP_ARMED, CMP_PENDING} cmp_state_e;
endpackage

// File: rtl/shtmr_counter.sv
module shtmr_counter
    import shtmr_pkg::*;
#(
    parameter int CW = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_stop,
    input  logic        lo_wr,
    input  logic        hi_wr,
    input  logic [31:0] wdata,
    output logic [63:0] cnt_wide,
    output logic [CW-1:0] cnt_o,
    output logic        halted
);
    cnt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [63:0]   load_w;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_RUN:  if (cfg_wr && cfg_stop)  state_d = CNT_HALT;
            CNT_HALT: if (cfg_wr && !cfg_stop) state_d = CNT_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        load_w = 64'(cnt_q);
        if (lo_wr) load_w[31:0]  = wdata;
        if (hi_wr) load_w[63:32] = wdata;
        if (lo_wr || hi_wr)         cnt_d = load_w[CW-1:0];
        else if (state_q == CNT_RUN) cnt_d = cnt_q + CW'(1);
        else                         cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_comb begin
        cnt_wide = 64'(cnt_q);
        cnt_o    = cnt_q;
        halted   = (state_q == CNT_HALT);
    end

    // R3: the high word moves only on a carry out of the low word
    a_r3_hi_on_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(lo_wr) && !$past(hi_wr) && ($past(cnt_wide[63:32]) != cnt_wide[63:32]))
        |-> ($past(cnt_wide[31:0]) == 32'hFFFF_FFFF));

    // R4: a halted counter holds its value when not written
    a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !lo_wr && !hi_wr) |=> $stable(cnt_wide));
endmodule

// File: rtl/shtmr_compare.sv
module shtmr_compare
    import shtmr_pkg::*;
#(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [31:0]   wdata,
    output logic [63:0]   cmp_wide,
    output logic          irq_o
);
    cmp_state_e    st_q, st_d;
    logic [31:0]   stage_q;
    logic [CW-1:0] cmp_q;
    logic [63:0]   commit_w;
    logic          hit, wr_any;

    assign commit_w = {stage_q, wdata};
    assign hit      = (cnt == cmp_q);
    assign wr_any   = wr_lo || wr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
            cmp_q   <= '1;
        end else begin
            if (wr_hi) stage_q <= wdata;
            if (wr_lo) cmp_q   <= commit_w[CW-1:0];
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CMP_ARMED:   if (!wr_any && hit) st_d = CMP_PENDING;
            CMP_PENDING: if (wr_any)         st_d = CMP_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CMP_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        irq_o    = (st_q == CMP_PENDING);
        cmp_wide = 64'(cmp_q);
    end

    // R7: pending stays set until the compare is written
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_any) |=> irq_o);

    // R7: any compare write leaves the interrupt low next cycle
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> !irq_o);

    // R8: a high-half write alone leaves the committed compare alone
    a_r8_hi_staged: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> $stable(cmp_wide));
endmodule

// File: rtl/shared_timer.sv
module shared_timer
    import shtmr_pkg::*;
#(
    parameter int NCTX  = 4,
    parameter int CNT_K = 8,
    parameter int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [3:0]        bus_addr,
    input  logic [CTX_W-1:0]  bus_ctx,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCTX-1:0]   timer_irq
);
    localparam int CW = 32 + 4 * CNT_K;

    logic          wr_en;
    logic          ctx_ok, sel_ok;
    logic [7:0]    sel;
    logic [7:0]    osel_q [NCTX];
    logic [63:0]   cmp_rd [NCTX];
    logic [NCTX-1:0] wr_lo, wr_hi;
    logic [63:0]   cnt64;
    logic [CW-1:0] cnt;
    logic          halted;
    logic [31:0]   rd_d, rd_q;

    assign wr_en  = bus_valid && bus_write;
    assign ctx_ok = (32'(bus_ctx) < NCTX);
    assign sel    = ctx_ok ? osel_q[bus_ctx] : 8'd0;
    assign sel_ok = ctx_ok && (32'(sel) < NCTX);

    shtmr_counter #(.CW(CW)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (wr_en && bus_addr == A_CFG),
        .cfg_stop (bus_wdata[0]),
        .lo_wr    (wr_en && bus_addr == A_CNT_LO),
        .hi_wr    (wr_en && bus_addr == A_CNT_HI),
        .wdata    (bus_wdata),
        .cnt_wide (cnt64),
        .cnt_o    (cnt),
        .halted   (halted)
    );

    for (genvar i = 0; i < NCTX; i++) begin : g_ctx
        logic loc_hit, oth_hit;
        assign loc_hit  = ctx_ok && (bus_ctx == CTX_W'(i));
        assign oth_hit  = sel_ok && (sel == 8'(i));
        assign wr_lo[i] = wr_en && ((bus_addr == A_CMP_LO && loc_hit) ||
                                    (bus_addr == A_OCMP_LO && oth_hit));
        assign wr_hi[i] = wr_en && ((bus_addr == A_CMP_HI && loc_hit) ||
                                    (bus_addr == A_OCMP_HI && oth_hit));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) osel_q[i] <= 8'd0;
            else if (wr_en && bus_addr == A_OSEL && loc_hit) osel_q[i] <= bus_wdata[7:0];
        end

        shtmr_compare #(.CW(CW)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt),
            .wr_lo    (wr_lo[i]),
            .wr_hi    (wr_hi[i]),
            .wdata    (bus_wdata),
            .cmp_wide (cmp_rd[i]),
            .irq_o    (timer_irq[i])
        );
    end

    always_comb begin
        rd_d = 32'd0;
        case (bus_addr)
            A_CFG:     rd_d = {20'd0, 4'(CNT_K), 7'd0, halted};
            A_CNT_LO:  rd_d = cnt64[31:0];
            A_CNT_HI:  rd_d = cnt64[63:32];
            A_OSEL:    rd_d = {24'd0, sel};
            A_CMP_LO:  if (ctx_ok) rd_d = cmp_rd[bus_ctx][31:0];
            A_CMP_HI:  if (ctx_ok) rd_d = cmp_rd[bus_ctx][63:32];
            A_OCMP_LO: if (sel_ok) rd_d = cmp_rd[sel[CTX_W-1:0]][31:0];
            A_OCMP_HI: if (sel_ok) rd_d = cmp_rd[sel[CTX_W-1:0]][63:32];
            default:   rd_d = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       rd_q <= 32'd0;
        else if (bus_valid && !bus_write) rd_q <= rd_d;
    end

    assign bus_rdata = rd_q;

    // R11: a read request updates the read data port one clock later
    a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_valid) || $past(bus_write)) |-> $stable(bus_rdata));
endmodule

// File: tb/shared_timer_bench.sv
`timescale 1ns/1ps
module shared_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_ctx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic [3:0]  irq_a, irq_b;
    int          n_checks = 0, n_errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    shared_timer u_shared_timer (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_ctx(bus_ctx), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_a), .timer_irq(irq_a));

    shared_timer #(.CNT_K(1)) u_shared_timer_k1 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_ctx(bus_ctx), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_b), .timer_irq(irq_b));

    function automatic logic [31:0] cfg_word(input int k, input bit stop);
        return (32'(k) << 8) | {31'd0, stop};
    endfunction

    function automatic logic [31:0] hi_masked(input logic [31:0] v, input int k);
        if (k >= 8) return v;
        return v & ((32'd1 << (4 * k)) - 32'd1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] c, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_ctx = c; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] c,
                      output logic [31:0] va, output logic [31:0] vb);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_ctx = c;
        @(negedge clk);
        va = rdata_a; vb = rdata_b;
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL R2 watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, a2, b2;
        logic [63:0] v, tgt;
        void'($urandom(32'd4242));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R5 reset state and width field
        check("R1 irq", {28'd0, irq_a}, 32'd0);
        rd(4'd0, 2'd0, a, b);
        check("R5 cfg a", a, cfg_word(8, 1'b0));
        check("R5 cfg b", b, cfg_word(1, 1'b0));
        rd(4'd2, 2'd0, a, b);
        check("R1 cnt hi", a, 32'd0);
        rd(4'd9, 2'd0, a, b);
        check("R1 cmp hi a", a, 32'hFFFF_FFFF);
        check("R5 cmp hi b", b, hi_masked(32'hFFFF_FFFF, 1));
        rd(4'd8, 2'd0, a, b);
        check("R1 cmp lo", a, 32'hFFFF_FFFF);

        // R2 running increment
        rd(4'd1, 2'd0, a, b);
        idle(5);
        rd(4'd1, 2'd0, a2, b2);
        check("R2 step", a2 - a, 32'd6);

        // R4 halt
        wr(4'd0, 2'd0, 32'd1);
        rd(4'd1, 2'd0, a, b);
        idle(4);
        rd(4'd1, 2'd0, a2, b2);
        check("R4 halted hold", a2, a);
        rd(4'd0, 2'd0, a, b);
        check("R4 stop readback", a, cfg_word(8, 1'b1));

        // R6 loading halves
        wr(4'd1, 2'd0, 32'h0000_1234);
        rd(4'd1, 2'd0, a, b);
        check("R6 lo load", a, 32'h0000_1234);
        wr(4'd2, 2'd0, 32'h0000_ABCD);
        rd(4'd2, 2'd0, a, b);
        check("R6 hi load a", a, 32'h0000_ABCD);
        check("R5 hi load b", b, hi_masked(32'h0000_ABCD, 1));
        rd(4'd1, 2'd0, a, b);
        check("R6 lo kept", a, 32'h0000_1234);

        // R3 / R4 carry: resume, 3 idle, halt -> 4 increments
        wr(4'd2, 2'd0, 32'd5);
        wr(4'd1, 2'd0, 32'hFFFF_FFFE);
        wr(4'd0, 2'd0, 32'd0);
        idle(3);
        wr(4'd0, 2'd0, 32'd1);
        rd(4'd1, 2'd0, a, b);
        check("R4 count lo", a, 32'd2);
        rd(4'd2, 2'd0, a, b);
        check("R3 carry hi", a, 32'd6);
        wr(4'd1, 2'd0, 32'd0);
        wr(4'd0, 2'd0, 32'd0);
        idle(10);
        wr(4'd0, 2'd0, 32'd1);
        rd(4'd1, 2'd0, a, b);
        check("R2 count lo", a, 32'd11);
        rd(4'd2, 2'd0, a, b);
        check("R3 hi no carry", a, 32'd6);

        // R11 unused addresses
        rd(4'd3, 2'd0, a, b);
        check("R11 addr3", a, 32'd0);
        rd(4'd15, 2'd1, a, b);
        check("R11 addr15", a, 32'd0);

        // R7 / R9 directed match on context 1
        wr(4'd2, 2'd0, 32'd0);
        wr(4'd1, 2'd0, 32'd100);
        wr(4'd9, 2'd1, 32'd0);
        wr(4'd8, 2'd1, 32'd103);
        wr(4'd0, 2'd0, 32'd0);
        idle(3);
        check("R7 not yet", {31'd0, irq_a[1]}, 32'd0);
        idle(1);
        check("R7 fires", {31'd0, irq_a[1]}, 32'd1);
        check("R9 ctx0 untouched", {31'd0, irq_a[0]}, 32'd0);
        idle(20);
        check("R7 sticky", {31'd0, irq_a[1]}, 32'd1);
        wr(4'd9, 2'd1, 32'd0);
        check("R7 cleared", {31'd0, irq_a[1]}, 32'd0);
        wr(4'd0, 2'd0, 32'd1);

        // R8 staging on context 2
        wr(4'd9, 2'd2, 32'h77);
        rd(4'd9, 2'd2, a, b);
        check("R8 hi staged", a, 32'hFFFF_FFFF);
        wr(4'd8, 2'd2, 32'h10);
        rd(4'd9, 2'd2, a, b);
        check("R8 hi commit", a, 32'h77);
        rd(4'd8, 2'd2, a, b);
        check("R8 lo commit", a, 32'h10);

        // R10 remote window
        wr(4'd4, 2'd0, 32'd3);
        wr(4'd13, 2'd0, 32'h55);
        wr(4'd12, 2'd0, 32'h66);
        rd(4'd9, 2'd3, a, b);
        check("R10 remote hi", a, 32'h55);
        rd(4'd8, 2'd3, a, b);
        check("R10 remote lo", a, 32'h66);
        rd(4'd9, 2'd0, a, b);
        check("R10 requester own", a, 32'hFFFF_FFFF);
        rd(4'd4, 2'd0, a, b);
        check("R10 sel readback", a, 32'd3);
        wr(4'd4, 2'd0, 32'd9);
        wr(4'd12, 2'd0, 32'h99);
        rd(4'd8, 2'd3, a, b);
        check("R10 bad sel ignored", a, 32'h66);
        rd(4'd12, 2'd0, a, b);
        check("R10 bad sel reads 0", a, 32'd0);

        // Random matches through both windows (R7 R9 R10)
        for (int it = 0; it < 16; it++) begin
            int t = int'($urandom % 4);
            int c = int'($urandom % 4);
            int d = 1 + int'($urandom % 6);
            bit oth = bit'($urandom % 2);
            v   = {$urandom, $urandom};
            tgt = v + 64'(d);
            wr(4'd2, 2'd0, v[63:32]);
            wr(4'd1, 2'd0, v[31:0]);
            if (oth) begin
                wr(4'd4, 2'(c), 32'(t));
                wr(4'd13, 2'(c), tgt[63:32]);
                wr(4'd12, 2'(c), tgt[31:0]);
            end else begin
                wr(4'd9, 2'(t), tgt[63:32]);
                wr(4'd8, 2'(t), tgt[31:0]);
            end
            rd(4'd9, 2'(t), a, b);
            check(oth ? "R10 rand hi" : "R9 rand hi", a, tgt[63:32]);
            rd(4'd8, 2'(t), a, b);
            check(oth ? "R10 rand lo" : "R9 rand lo", a, tgt[31:0]);
            wr(4'd0, 2'd0, 32'd0);
            idle(d);
            check("R7 rand early", {31'd0, irq_a[t]}, 32'd0);
            idle(1);
            check("R7 rand fire", {31'd0, irq_a[t]}, 32'd1);
            wr(4'd0, 2'd0, 32'd1);
        end

        // R5 wrap at the configured width
        wr(4'd2, 2'd0, 32'hFFFF_FFFF);
        wr(4'd1, 2'd0, 32'hFFFF_FFFD);
        rd(4'd2, 2'd0, a, b);
        check("R5 hi a", a, 32'hFFFF_FFFF);
        check("R5 hi b masked", b, hi_masked(32'hFFFF_FFFF, 1));
        wr(4'd0, 2'd0, 32'd0);
        idle(2);
        wr(4'd0, 2'd0, 32'd1);
        rd(4'd1, 2'd0, a, b);
        check("R5 wrap lo a", a, 32'd0);
        check("R5 wrap lo b", b, 32'd0);
        rd(4'd2, 2'd0, a, b);
        check("R5 wrap hi a", a, 32'd0);
        check("R5 wrap hi b", b, 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule